// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a run of data words between a peripheral stream and a range of consecutive memory locations so that the processor does not have to copy them itself. The processor loads a first address, a word count, a direction and an ownership mode on the configuration pins and pulses a start strobe. The engine then asks for the memory bus with a request line. It moves one word in each cycle in which the bus is granted and the peripheral side can take part. The processor keeps running between the words the engine takes.

Two bus ownership modes are offered. In cycle-stealing mode the engine lets go of its request after every word for one cycle and then asks again, so processor accesses can slip in between words. In burst mode the request stays high from the start until the last word has moved. When the count is used up the engine drops its request, raises a sticky done flag and pulses an interrupt request for one cycle. A start with a count of zero finishes at once without touching the bus.

The peripheral side is two valid/ready streams. For transfers into memory the peripheral drives `in_valid`/`in_data`, and the engine raises `in_ready` only in cycles where it owns the bus and the grant is present. A word moves when both `in_valid` and `in_ready` are high. The peripheral must hold `in_data` steady while `in_valid` is high and no handshake has taken place. For transfers out of memory the engine raises `out_valid` while it owns a granted bus, with `out_data` taken straight from memory read data. The memory read strobe fires only in cycles where the sink shows `out_ready`. `out_valid` may fall without a handshake when the grant is withdrawn. Memory is modelled as combinational read data for `mem_addr` and a write on the clock edge when `mem_wr` is high.

Top module: `dma_mover`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `bus_req`, `in_ready` and `out_valid` are all low. A start with a nonzero count sets `busy` and `bus_req` high in the cycle after the start strobe, and `bus_req` is never high while `busy` is low.
- R2: Word k of a transfer (counting from 0) uses memory address (first address + k) modulo 2^AW. Locations outside that range are not written.
- R3: `mem_wr` or `mem_rd` is high only in a cycle where `bus_req` and `bus_grant` are both high.
- R4: With `start_dir` = 0 (peripheral into memory), `mem_wr` fires only with `in_valid` and `in_ready` both high. It writes `in_data` to the current address, and `mem_rd` stays low.
- R5: With `start_dir` = 1 (memory out to peripheral), `mem_rd` fires only with `out_valid` and `out_ready` both high. `out_data` equals the memory word at the current address, and `mem_wr` stays low.
- R6: With `start_burst` = 0 (cycle stealing), after every word except the last `bus_req` is low for exactly one cycle and then high again.
- R7: With `start_burst` = 1 (burst), `bus_req` stays high in every cycle from the one after the start until the last word moves.
- R8: In the cycle after the last word, `busy` and `bus_req` are low, `done` is high and `irq` is high for that one cycle only. A later accepted start clears `done` in the following cycle.
- R9: A start with a count of 0 gives `done` and `irq` high and `busy` low in the next cycle, and `bus_req` is never raised.
- R10: A transfer moves exactly the programmed number of words.
- R11: A start strobe while `busy` is high is ignored: the running transfer keeps its addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| start_addr | input | AW | First memory address |
| start_count | input | CW | Number of words to move |
| start_dir | input | 1 | 0 into memory, 1 out of memory |
| start_burst | input | 1 | 0 cycle stealing, 1 burst |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt request |
| bus_req | output | 1 | Memory bus request |
| bus_grant | input | 1 | Memory bus grant |
| mem_addr | output | AW | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| in_valid | input | 1 | Inbound stream valid |
| in_ready | output | 1 | Inbound stream ready |
| in_data | input | DW | Inbound stream data |
| out_valid | output | 1 | Outbound stream valid |
| out_ready | input | 1 | Outbound stream ready |
| out_data | output | DW | Outbound stream data |

## Verification
The bench sweeps both directions and both modes over counts of one, three and seven words. It uses a continuous grant and willing peripheral as well as pseudo-random grant and handshake patterns. Single-word transfers catch an engine that decides "last word" off by one and so asks for the bus again or never finishes. A range ending at the top of the address space catches address arithmetic that does not wrap. Random grant gaps in burst mode catch an engine that drops its request while waiting. A zero count catches a design that raises `bus_req` or underflows its counter into a 256-word run. A start strobe in the middle of a transfer catches an engine that reloads its cursor and jumps to new addresses.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_OWN   = 2'd1,
    XS_YIELD = 2'd2
  } xfer_state_t;

  typedef enum logic {
    DIR_TO_MEM   = 1'b0,
    DIR_FROM_MEM = 1'b1
  } xfer_dir_t;

  typedef enum logic {
    MODE_STEAL = 1'b0,
    MODE_BURST = 1'b1
  } own_mode_t;

  typedef struct packed {
    xfer_dir_t dir;
    own_mode_t mode;
  } xfer_cfg_t;

endpackage

// File: rtl/dma_mover_cursor.sv
module dma_mover_cursor
  import dma_mover_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_count,
  input  xfer_cfg_t     load_cfg,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] left,
  output xfer_cfg_t     cfg,
  output logic          last,
  output logic          load_zero
);

  localparam logic [CW-1:0] ONE_WORD = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      left <= '0;
      cfg  <= '{dir: DIR_TO_MEM, mode: MODE_STEAL};
    end else if (load) begin
      addr <= load_addr;
      left <= load_count;
      cfg  <= load_cfg;
    end else if (step) begin
      addr <= addr + 1'b1;
      left <= left - 1'b1;
    end
  end

  assign last      = (left == ONE_WORD);
  assign load_zero = (load_count == '0);

endmodule

// File: rtl/dma_mover_ctrl.sv
module dma_mover_ctrl
  import dma_mover_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_zero,
  input  logic        burst,
  input  logic        fire,
  input  logic        last,
  output logic        accept,
  output xfer_state_t state,
  output logic        busy,
  output logic        done,
  output logic        irq
);

  xfer_state_t state_nx;
  logic        finish_nx;

  assign accept = start && (state == XS_IDLE);

  always_comb begin
    state_nx  = state;
    finish_nx = 1'b0;
    unique case (state)
      XS_IDLE: begin
        if (accept) begin
          if (start_zero) finish_nx = 1'b1;
          else            state_nx  = XS_OWN;
        end
      end
      XS_OWN: begin
        if (fire) begin
          if (last) begin
            state_nx  = XS_IDLE;
            finish_nx = 1'b1;
          end else if (!burst) begin
            state_nx = XS_YIELD;
          end
        end
      end
      XS_YIELD: state_nx = XS_OWN;
      default:  state_nx = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= XS_IDLE;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= state_nx;
      irq   <= finish_nx;
      if (finish_nx)   done <= 1'b1;
      else if (accept) done <= 1'b0;
    end
  end

  assign busy = (state != XS_IDLE);

endmodule

// File: rtl/dma_mover_port.sv
module dma_mover_port
  import dma_mover_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          own,
  input  logic          grant,
  input  xfer_dir_t     dir,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          out_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  output logic          fire
);

  logic held;

  assign held      = own && grant;
  assign in_ready  = held && (dir == DIR_TO_MEM);
  assign out_valid = held && (dir == DIR_FROM_MEM);
  assign mem_wr    = in_ready && in_valid;
  assign mem_rd    = out_valid && out_ready;
  assign mem_wdata = in_data;
  assign out_data  = mem_rdata;
  assign fire      = mem_wr || mem_rd;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_count,
  input  logic          start_dir,
  input  logic          start_burst,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  xfer_cfg_t   load_cfg;
  xfer_cfg_t   cur_cfg;
  xfer_state_t state;
  logic [CW-1:0] remaining;
  logic accept;
  logic fire;
  logic last;
  logic load_zero;
  logic cur_burst;

  assign load_cfg  = '{dir: xfer_dir_t'(start_dir), mode: own_mode_t'(start_burst)};
  assign cur_burst = (cur_cfg.mode == MODE_BURST);
  assign bus_req   = (state == XS_OWN);

  dma_mover_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_addr  (start_addr),
    .load_count (start_count),
    .load_cfg   (load_cfg),
    .step       (fire),
    .addr       (mem_addr),
    .left       (remaining),
    .cfg        (cur_cfg),
    .last       (last),
    .load_zero  (load_zero)
  );

  dma_mover_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_zero (load_zero),
    .burst      (cur_burst),
    .fire       (fire),
    .last       (last),
    .accept     (accept),
    .state      (state),
    .busy       (busy),
    .done       (done),
    .irq        (irq)
  );

  dma_mover_port #(.DW(DW)) u_port (
    .own       (bus_req),
    .grant     (bus_grant),
    .dir       (cur_cfg.dir),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_ready (out_ready),
    .mem_rdata (mem_rdata),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_wdata (mem_wdata),
    .fire      (fire)
  );

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic          bus_req,
  input logic          bus_grant,
  input logic [AW-1:0] mem_addr,
  input logic          mem_wr,
  input logic          mem_rd,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          mode_burst,
  input logic [CW-1:0] left
);

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  assert_owned_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> (bus_req && bus_grant));

  assert_write_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (in_valid && in_ready && !mem_rd));

  assert_read_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (out_valid && out_ready && !mem_wr));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || mem_rd) && !mode_burst) |=> !bus_req);

  assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || mem_rd) && mode_burst && (left > CW'(1))) |=> bus_req);

  assert_irq_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !busy));

endmodule

bind dma_mover dma_mover_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .irq        (irq),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .mem_addr   (mem_addr),
  .mem_wr     (mem_wr),
  .mem_rd     (mem_rd),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .mode_burst (cur_burst),
  .left       (remaining)
);

// File: tb/dma_mover_test.sv
`timescale 1ns/1ps
module dma_mover_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] start_count = '0;
  logic start_dir = 1'b0;
  logic start_burst = 1'b0;
  logic busy, done, irq, bus_req;
  logic bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_wr, mem_rd;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;

  logic [DW-1:0] mem [DEPTH];
  assign mem_rdata = mem[mem_addr];

  int checks = 0;
  int fails = 0;
  logic [15:0] rng = 16'hACE1;

  dma_mover #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_count(start_count), .start_dir(start_dir), .start_burst(start_burst),
    .busy(busy), .done(done), .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial forever #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 5);
  endfunction

  function automatic logic [DW-1:0] src(input int k, input int salt);
    return DW'(16'hA000 + k * 3 + salt);
  endfunction

  task automatic tick_rng;
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
  endtask

  task automatic run_xfer(input int a0, input int n, input bit dir, input bit burst,
                          input bit gfull, input bit pfull, input bit poke);
    int words = 0, addr_err = 0, own_err = 0, hs_err = 0, data_err = 0;
    int steal_err = 0, burst_err = 0, late_irq = 0, mem_err = 0, cyc = 0;
    bit prev_fire = 0, gap_prev = 0, fin = 0, f;
    for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(a0); start_count = CW'(n);
    start_dir = dir; start_burst = burst;
    bus_grant = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy && bus_req, "R1", "busy and bus_req after start", {busy, bus_req}, 3);
    chk(!done, "R8", "done cleared by new start", done, 0);
    while (!fin && cyc < 4000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (irq) begin
        fin = 1;
      end else begin
        if (prev_fire && words == n) late_irq++;
        if (!burst) begin
          if (prev_fire && bus_req) steal_err++;
          if (gap_prev && !bus_req) steal_err++;
          gap_prev = prev_fire;
        end else if (!bus_req) begin
          burst_err++;
        end
        bus_grant = gfull | rng[0];
        in_valid  = pfull | rng[3];
        out_ready = pfull | rng[6];
        tick_rng();
        in_data = src(words, n);
        if (poke && cyc == 3) begin
          start = 1'b1; start_addr = AW'(a0 + 100); start_count = CW'(2);
          start_dir = ~dir; start_burst = ~burst;
        end else begin
          start = 1'b0;
        end
        #1;
        f = mem_wr | mem_rd;
        if (f && !(bus_req && bus_grant)) own_err++;
        if (mem_wr && (!in_valid || dir)) hs_err++;
        if (mem_rd && (!out_ready || !dir)) hs_err++;
        if (f) begin
          if (mem_addr != AW'(a0 + words)) addr_err++;
          if (dir) begin
            if (out_data != pat((a0 + words) % DEPTH)) data_err++;
          end else begin
            if (mem_wdata != src(words, n)) data_err++;
            mem[mem_addr] = mem_wdata;
          end
          words++;
        end
        prev_fire = f;
      end
    end
    start = 1'b0;
    chk(fin, "R8", "irq seen after transfer", fin, 1);
    chk(words == n, "R10", "words moved", words, n);
    chk(late_irq == 0, "R8", "irq in cycle after last word", late_irq, 0);
    chk(!busy && done && !bus_req, "R8", "busy/done/bus_req at completion",
        {busy, done, bus_req}, 3'b010);
    chk(addr_err == 0, "R2", "address sequence errors", addr_err, 0);
    chk(own_err == 0, "R3", "accesses without owned grant", own_err, 0);
    if (dir) begin
      chk(hs_err == 0, "R5", "read handshake errors", hs_err, 0);
      chk(data_err == 0, "R5", "outbound data errors", data_err, 0);
    end else begin
      chk(hs_err == 0, "R4", "write handshake errors", hs_err, 0);
      chk(data_err == 0, "R4", "inbound data errors", data_err, 0);
      for (int k = 0; k < n; k++)
        if (mem[(a0 + k) % DEPTH] != src(k, n)) mem_err++;
      chk(mem_err == 0, "R4", "memory contents after inbound run", mem_err, 0);
    end
    chk(mem[(a0 + DEPTH - 1) % DEPTH] == pat((a0 + DEPTH - 1) % DEPTH) &&
        mem[(a0 + n) % DEPTH] == pat((a0 + n) % DEPTH),
        "R2", "neighbours untouched", mem[(a0 + n) % DEPTH], pat((a0 + n) % DEPTH));
    if (burst) chk(burst_err == 0, "R7", "burst request drops", burst_err, 0);
    else       chk(steal_err == 0, "R6", "steal gap errors", steal_err, 0);
    if (poke)  chk(words == n && addr_err == 0, "R11", "start while busy ignored", words, n);
    bus_grant = 1'b0;
    @(negedge clk);
    chk(!irq && done, "R8", "irq lasts one cycle, done stays", {irq, done}, 1);
  endtask

  task automatic run_zero(input int a0);
    @(negedge clk);
    start = 1'b1; start_addr = AW'(a0); start_count = '0; bus_grant = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && irq && !busy, "R9", "zero count completes next cycle",
        {done, irq, busy}, 3'b110);
    chk(!bus_req, "R9", "zero count never requests", bus_req, 0);
    @(negedge clk);
    chk(!bus_req && !irq && !busy, "R9", "zero count stays idle", {bus_req, irq, busy}, 0);
    bus_grant = 1'b0;
  endtask

  initial begin
    int cnts[3] = '{1, 3, 7};
    for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !irq && !bus_req && !in_ready && !out_valid, "R1",
        "reset state", {busy, done, irq, bus_req, in_ready, out_valid}, 0);
    run_zero(10);
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        for (int m = 0; m < 3; m++)
          for (int c = 0; c < 3; c++)
            run_xfer((m == 1) ? 252 : (16 * d + 40 * b + 5 + c),
                     cnts[c], d[0], b[0], (m != 1), (m == 0), 1'b0);
    run_xfer(30, 7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_xfer(60, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    run_xfer(255, 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_zero(200);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule